// File: doc/BRIEF.md
# Two-Wire Bus Slave Front-End with Address Gating

This block sits between the two open-drain lines of a two-wire serial bus (the I2C protocol, 7-bit addressing only) and the command layer of a small peripheral. It over-samples the clock and data lines with the system clock and finds bus conditions and clock edges on the synchronised samples. The system clock must run at least eight times faster than the bus clock. It then walks each transfer bit by bit: address, direction bit, data bytes and acknowledge clocks.

The device address is seven bits. The upper six bits are fixed by a parameter and the lowest bit comes from a strap pin. The incoming address is checked one bit at a time. At the first bit that differs, the front-end goes deaf to the bus clock until the bus shows a fresh start condition. It does the same after every stop condition. In write transfers it hands each received byte to the command layer with a one-cycle strobe and acknowledges it. In read transfers it takes each outgoing byte from the command layer and shifts it out, and it stops sending when the master does not acknowledge. The only output to the pad is an enable that pulls the data line low.

Top module: `i2c_slave_front`

## Requirements
- R1: A falling data line while the clock line is high produces a one-cycle `start_p` and opens an address phase. A rising data line while the clock line is high produces a one-cycle `stop_p` and ends any transfer.
- R2: The device address is {`ADDR_HI`, `addr_sel`}, sent MSB first, followed by the direction bit (0 = write, 1 = read). On a full match, `sda_oe` is high for the whole ninth clock, `addr_hit` pulses once, and `rd_mode` holds the direction bit.
- R3: At the first address bit that differs, the block stops reacting to the clock line. Until the next start it drives no acknowledge, gives no `rx_valid` and gives no `ack_fall`.
- R4: After a stop, clock pulses on the bus are ignored until the next start.
- R5: In a write transfer, data bytes arrive MSB first. `rx_valid` pulses for one cycle at the eighth rising clock edge while `rx_byte` holds the byte, and the block acknowledges every byte.
- R6: `ack_fall` pulses for one cycle at the falling clock edge that closes every acknowledge clock the block takes part in.
- R7: In a read transfer, `tx_byte` is sampled in the cycle `ack_fall` pulses and sent MSB first. `sda_oe` is high exactly while a 0 bit is sent, changes only while the clock line is low, and is released for the ninth clock.
- R8: A master acknowledge (data low at the ninth rising clock edge) starts the next byte. A non-acknowledge ends the transmission, and the data line stays released until the next start.
- R9: A stop in the same clock-high pulse as the start before it is ignored. It gives no `stop_p`, and address reception carries on.
- R10: The all-zero general call address is never acknowledged.
- R11: A repeated start in the middle of a transfer opens a new address phase, and this phase may change the direction.
- R12: In reset, `sda_oe`, all strobes and `rd_mode` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| addr_sel | input | 1 | Strap that sets the lowest address bit |
| tx_byte | input | 8 | Next byte to send in a read transfer |
| sda_oe | output | 1 | High pulls the data line low |
| start_p | output | 1 | One-cycle pulse on a start or repeated start |
| stop_p | output | 1 | One-cycle pulse on an accepted stop |
| addr_hit | output | 1 | One-cycle pulse when the address matched |
| rd_mode | output | 1 | Direction bit of the last addressed transfer |
| rx_byte | output | 8 | Last byte received in a write transfer |
| rx_valid | output | 1 | One-cycle strobe, `rx_byte` is new |
| ack_fall | output | 1 | One-cycle strobe at the end of an acknowledge clock |

## Verification
The properties assume that the master moves the data line only while the clock line is low, except for start and stop conditions. They also assume that each clock level lasts well over the three system cycles of synchroniser delay. Under these assumptions, a change of `sda_oe` can be checked against the raw clock pin being low. The bench master holds each half of the clock for ten system cycles and changes data five cycles into the low phase. It starts or stops only while the block has released the line. The one deliberate break of the usual framing, a stop in the same high pulse as its start, is timed to the same ten-cycle grid.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ADDR_W = 7;
  localparam int unsigned CNT_W  = $clog2(BYTE_W + 1);
  localparam int unsigned AIDX_W = $clog2(ADDR_W);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WR,
    ST_WACK,
    ST_RD,
    ST_RACK
  } bus_st_t;
endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar g = 0; g < W; g++) begin : g_line
    logic [STAGES-1:0] ff;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ff <= '1;
      else        ff <= {ff[STAGES-2:0], d[g]};
    end
    assign q[g] = ff[STAGES-1];
  end
endmodule

// File: rtl/i2cs_cond.sv
module i2cs_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_ok
);
  logic scl_d, sda_d, st_hi;
  logic st_hi_n;
  logic stop_det;

  always_comb begin
    scl_rise  = scl_s & ~scl_d;
    scl_fall  = ~scl_s & scl_d;
    start_det = scl_s & scl_d & sda_d & ~sda_s;
    stop_det  = scl_s & scl_d & ~sda_d & sda_s;
    // a stop inside the same high pulse as its start is dropped
    stop_ok   = stop_det & ~st_hi;
    st_hi_n   = st_hi;
    if (start_det)     st_hi_n = 1'b1;
    else if (scl_fall) st_hi_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
      st_hi <= 1'b0;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
      st_hi <= st_hi_n;
    end
  end
endmodule

// File: rtl/i2cs_fsm.sv
module i2cs_fsm
  import i2cs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_ok,
  input  logic              sda_s,
  input  logic [ADDR_W-1:0] dev_addr,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic              sda_oe,
  output logic              start_p,
  output logic              stop_p,
  output logic              addr_hit,
  output logic              rd_mode,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              rx_valid,
  output logic              ack_fall
);
  bus_st_t           st, st_n;
  logic [CNT_W-1:0]  cnt, cnt_n;
  logic [BYTE_W-2:0] sh, sh_n;
  logic [BYTE_W-2:0] txsh, txsh_n;
  logic              rw, rw_n, mack, mack_n, oe, oe_n;
  logic [BYTE_W-1:0] rxb, rxb_n;
  logic              start_n, stop_n, rxv_n, ackf_n, hit_n;
  logic [AIDX_W-1:0] aidx;
  logic              addr_bad;
  logic              byte_end;
  logic              load_tx;

  always_comb begin
    aidx     = AIDX_W'(ADDR_W - 1) - cnt[AIDX_W-1:0];
    addr_bad = (sda_s != dev_addr[aidx]) || (dev_addr == '0);
    byte_end = (cnt == CNT_W'(BYTE_W));
  end

  always_comb begin
    st_n    = st;
    cnt_n   = cnt;
    sh_n    = sh;
    txsh_n  = txsh;
    rw_n    = rw;
    mack_n  = mack;
    oe_n    = oe;
    rxb_n   = rxb;
    start_n = 1'b0;
    stop_n  = 1'b0;
    rxv_n   = 1'b0;
    ackf_n  = 1'b0;
    hit_n   = 1'b0;
    load_tx = 1'b0;
    if (start_det) begin
      st_n    = ST_ADDR;
      cnt_n   = '0;
      oe_n    = 1'b0;
      start_n = 1'b1;
    end else if (stop_ok) begin
      st_n   = ST_IDLE;
      oe_n   = 1'b0;
      stop_n = 1'b1;
    end else begin
      case (st)
        ST_IDLE: ;
        ST_ADDR: begin
          if (scl_rise) begin
            if (cnt < CNT_W'(ADDR_W)) begin
              if (addr_bad) st_n  = ST_IDLE;
              else          cnt_n = cnt + CNT_W'(1);
            end else begin
              rw_n  = sda_s;
              cnt_n = cnt + CNT_W'(1);
            end
          end else if (scl_fall && byte_end) begin
            oe_n  = 1'b1;
            hit_n = 1'b1;
            st_n  = ST_AACK;
            cnt_n = '0;
          end
        end
        ST_AACK: begin
          if (scl_fall) begin
            ackf_n = 1'b1;
            cnt_n  = '0;
            if (rw) begin
              load_tx = 1'b1;
              st_n    = ST_RD;
            end else begin
              oe_n = 1'b0;
              st_n = ST_WR;
            end
          end
        end
        ST_WR: begin
          if (scl_rise) begin
            sh_n  = {sh[BYTE_W-3:0], sda_s};
            cnt_n = cnt + CNT_W'(1);
            if (cnt == CNT_W'(BYTE_W - 1)) begin
              rxv_n = 1'b1;
              rxb_n = {sh, sda_s};
            end
          end else if (scl_fall && byte_end) begin
            oe_n = 1'b1;
            st_n = ST_WACK;
          end
        end
        ST_WACK: begin
          if (scl_fall) begin
            ackf_n = 1'b1;
            oe_n   = 1'b0;
            st_n   = ST_WR;
            cnt_n  = '0;
          end
        end
        ST_RD: begin
          if (scl_rise) begin
            cnt_n = cnt + CNT_W'(1);
          end else if (scl_fall) begin
            if (byte_end) begin
              oe_n = 1'b0;
              st_n = ST_RACK;
            end else begin
              oe_n   = ~txsh[BYTE_W-2];
              txsh_n = {txsh[BYTE_W-3:0], 1'b0};
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            mack_n = ~sda_s;
          end else if (scl_fall) begin
            ackf_n = 1'b1;
            cnt_n  = '0;
            if (mack) begin
              load_tx = 1'b1;
              st_n    = ST_RD;
            end else begin
              oe_n = 1'b0;
              st_n = ST_IDLE;
            end
          end
        end
        default: st_n = ST_IDLE;
      endcase
    end
    if (load_tx) begin
      txsh_n = tx_byte[BYTE_W-2:0];
      oe_n   = ~tx_byte[BYTE_W-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      sh       <= '0;
      txsh     <= '0;
      rw       <= 1'b0;
      mack     <= 1'b0;
      oe       <= 1'b0;
      rxb      <= '0;
      start_p  <= 1'b0;
      stop_p   <= 1'b0;
      rx_valid <= 1'b0;
      ack_fall <= 1'b0;
      addr_hit <= 1'b0;
    end else begin
      st       <= st_n;
      cnt      <= cnt_n;
      sh       <= sh_n;
      txsh     <= txsh_n;
      rw       <= rw_n;
      mack     <= mack_n;
      oe       <= oe_n;
      rxb      <= rxb_n;
      start_p  <= start_n;
      stop_p   <= stop_n;
      rx_valid <= rxv_n;
      ack_fall <= ackf_n;
      addr_hit <= hit_n;
    end
  end

  assign sda_oe  = oe;
  assign rd_mode = rw;
  assign rx_byte = rxb;
endmodule

// File: rtl/i2c_slave_front.sv
module i2c_slave_front
  import i2cs_pkg::*;
#(
  parameter logic [ADDR_W-2:0] ADDR_HI     = 6'b011100,
  parameter int unsigned       SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              addr_sel,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic              sda_oe,
  output logic              start_p,
  output logic              stop_p,
  output logic              addr_hit,
  output logic              rd_mode,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              rx_valid,
  output logic              ack_fall
);
  logic [1:0] rst_sh;
  logic       rst_i_n;
  logic [1:0] lines_s;
  logic       scl_rise, scl_fall, start_det, stop_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh <= 2'b00;
    else        rst_sh <= {rst_sh[0], 1'b1};
  end
  assign rst_i_n = rst_sh[1];

  i2cs_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_i_n), .d({scl_i, sda_i}), .q(lines_s)
  );

  i2cs_cond u_cond (
    .clk(clk), .rst_n(rst_i_n),
    .scl_s(lines_s[1]), .sda_s(lines_s[0]),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_ok(stop_ok)
  );

  i2cs_fsm u_fsm (
    .clk(clk), .rst_n(rst_i_n),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_ok(stop_ok),
    .sda_s(lines_s[0]),
    .dev_addr({ADDR_HI, addr_sel}),
    .tx_byte(tx_byte),
    .sda_oe(sda_oe), .start_p(start_p), .stop_p(stop_p),
    .addr_hit(addr_hit), .rd_mode(rd_mode),
    .rx_byte(rx_byte), .rx_valid(rx_valid), .ack_fall(ack_fall)
  );
endmodule

// File: rtl/i2c_slave_front_chk.sv
module i2c_slave_front_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_i,
  input logic sda_oe,
  input logic start_p,
  input logic stop_p,
  input logic addr_hit,
  input logic rd_mode,
  input logic rx_valid,
  input logic ack_fall
);
  p_cond_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_p && stop_p));
  p_start_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start_p |=> !start_p);
  p_hit_acks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    addr_hit |-> sda_oe);
  p_stop_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stop_p |-> !sda_oe);
  p_rx_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (!rd_mode && !sda_oe));
  p_rx_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  p_ackf_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fall |=> !ack_fall);
  p_oe_scl_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i);
  p_start_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
    start_p |-> !sda_oe);
endmodule

bind i2c_slave_front i2c_slave_front_chk i_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
  .start_p(start_p), .stop_p(stop_p), .addr_hit(addr_hit),
  .rd_mode(rd_mode), .rx_valid(rx_valid), .ack_fall(ack_fall)
);

// File: tb/test_i2c_slave_front.sv
`timescale 1ns/1ps
module test_i2c_slave_front;
  localparam int Q = 5;

  logic clk = 1'b0;
  logic rst_n;
  logic m_scl, m_sda, addr_sel;
  logic [7:0] tx_byte;
  logic sda_oe, start_p, stop_p, addr_hit, rd_mode, rx_valid, ack_fall;
  logic [7:0] rx_byte;
  wire  sda_bus = m_sda & ~sda_oe;

  always #5 clk = ~clk;

  i2c_slave_front i_i2c_slave_front (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
    .addr_sel(addr_sel), .tx_byte(tx_byte), .sda_oe(sda_oe),
    .start_p(start_p), .stop_p(stop_p), .addr_hit(addr_hit),
    .rd_mode(rd_mode), .rx_byte(rx_byte), .rx_valid(rx_valid),
    .ack_fall(ack_fall)
  );

  int checks = 0, failures = 0, cyc = 0;
  int n_start, n_stop, n_hit, n_ackf;
  logic [7:0] rxq[$];
  logic [7:0] txq[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // behavioural reference model state
  logic hs[4], hd[4];
  int ms, mc, mv, mtx, mbit;
  bit msthi, mmack, mrw;
  bit e_oe, e_st, e_sp, e_hit, e_rv, e_af;
  int e_rb;

  task automatic model_reset();
    for (int i = 0; i < 4; i++) begin hs[i] = 1; hd[i] = 1; end
    ms = 0; mc = 0; mv = 0; mtx = 0; mbit = 0;
    msthi = 0; mmack = 0; mrw = 0;
    e_oe = 0; e_st = 0; e_sp = 0; e_hit = 0; e_rv = 0; e_af = 0; e_rb = 0;
  endtask

  task automatic model_step();
    bit cs, ps, cd, pd, rise, fall, sdet, pdet, hi_before;
    int myaddr, want;
    cs = hs[2]; ps = hs[3]; cd = hd[2]; pd = hd[3];
    rise = cs && !ps; fall = !cs && ps;
    sdet = cs && ps && pd && !cd;
    pdet = cs && ps && !pd && cd;
    e_st = 0; e_sp = 0; e_hit = 0; e_rv = 0; e_af = 0;
    hi_before = msthi;
    if (sdet) msthi = 1; else if (fall) msthi = 0;
    myaddr = 'h38 | int'(addr_sel);
    if (sdet) begin
      ms = 1; mc = 0; e_oe = 0; e_st = 1;
    end else if (pdet && !hi_before) begin
      ms = 0; e_oe = 0; e_sp = 1;
    end else begin
      case (ms)
        1: if (rise) begin
             if (mc < 7) begin
               want = (myaddr >> (6 - mc)) & 1;
               if (int'(cd) != want || myaddr == 0) ms = 0; else mc++;
             end else begin
               mrw = cd; mc++;
             end
           end else if (fall && mc == 8) begin
             e_oe = 1; e_hit = 1; ms = 2; mc = 0;
           end
        2: if (fall) begin
             e_af = 1; mc = 0;
             if (mrw) begin
               mtx = tx_byte; mbit = 7; e_oe = !tx_byte[7]; ms = 5;
             end else begin
               e_oe = 0; ms = 3;
             end
           end
        3: if (rise) begin
             mv = ((mv << 1) | int'(cd)) & 255; mc++;
             if (mc == 8) begin e_rv = 1; e_rb = mv; end
           end else if (fall && mc == 8) begin
             e_oe = 1; ms = 4;
           end
        4: if (fall) begin e_af = 1; e_oe = 0; ms = 3; mc = 0; end
        5: if (rise) mc++;
           else if (fall) begin
             if (mc == 8) begin e_oe = 0; ms = 6; end
             else begin mbit--; e_oe = !((mtx >> mbit) & 1); end
           end
        6: if (rise) mmack = !cd;
           else if (fall) begin
             e_af = 1; mc = 0;
             if (mmack) begin
               mtx = tx_byte; mbit = 7; e_oe = !tx_byte[7]; ms = 5;
             end else begin
               e_oe = 0; ms = 0;
             end
           end
        default: ;
      endcase
    end
  endtask

  // per-clock comparison, monitors, tx feed, watchdog, model
  always @(negedge clk) begin
    cyc++;
    chk(sda_oe == e_oe, "R7", "sda_oe", sda_oe, e_oe);
    chk(start_p == e_st, "R1", "start_p", start_p, e_st);
    chk(stop_p == e_sp, "R1", "stop_p", stop_p, e_sp);
    chk(addr_hit == e_hit, "R2", "addr_hit", addr_hit, e_hit);
    chk(rd_mode == mrw, "R2", "rd_mode", rd_mode, mrw);
    chk(rx_valid == e_rv, "R5", "rx_valid", rx_valid, e_rv);
    chk(rx_byte == e_rb[7:0], "R5", "rx_byte", rx_byte, e_rb);
    chk(ack_fall == e_af, "R6", "ack_fall", ack_fall, e_af);
    if (start_p) n_start++;
    if (stop_p) n_stop++;
    if (addr_hit) n_hit++;
    if (ack_fall) n_ackf++;
    if (rx_valid) rxq.push_back(rx_byte);
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
    #1;
    if (ack_fall && rd_mode && txq.size() > 0) tx_byte = txq.pop_front();
    #1;
    for (int i = 3; i > 0; i--) begin hs[i] = hs[i-1]; hd[i] = hd[i-1]; end
    hs[0] = m_scl; hd[0] = sda_bus;
    if (!rst_n) model_reset(); else model_step();
  end

  // master-side bus tasks
  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask
  task automatic clr();
    n_start = 0; n_stop = 0; n_hit = 0; n_ackf = 0; rxq.delete();
  endtask
  task automatic b_start();
    m_sda = 0; tick(Q); m_scl = 0; tick(Q);
  endtask
  task automatic b_rstart();
    m_sda = 1; tick(Q); m_scl = 1; tick(Q); m_sda = 0; tick(Q); m_scl = 0; tick(Q);
  endtask
  task automatic b_stop();
    m_sda = 0; tick(Q); m_scl = 1; tick(Q); m_sda = 1; tick(2*Q);
  endtask
  task automatic b_bit(input bit b, output bit s);
    m_sda = b; tick(Q); m_scl = 1; tick(Q); s = sda_bus; tick(Q); m_scl = 0; tick(Q);
  endtask
  task automatic wr_byte(input logic [7:0] v, output bit acked);
    bit s;
    for (int i = 7; i >= 0; i--) b_bit(v[i], s);
    b_bit(1'b1, s);
    acked = !s;
  endtask
  task automatic rd_byte(input bit give_ack, output logic [7:0] v);
    bit s;
    v = '0;
    for (int i = 0; i < 8; i++) begin b_bit(1'b1, s); v = {v[6:0], s}; end
    b_bit(!give_ack, s);
  endtask

  initial begin
    bit a;
    logic [7:0] v;
    m_scl = 1; m_sda = 1; addr_sel = 1; tx_byte = 8'h00; rst_n = 0;
    model_reset();
    tick(6);
    // R12 reset state
    chk(!sda_oe && !start_p && !stop_p && !rx_valid && !ack_fall && !rd_mode,
        "R12", "reset outputs", {sda_oe, start_p, stop_p, rx_valid, ack_fall, rd_mode}, 0);
    rst_n = 1; tick(6);

    // write transfer to 0x39
    clr(); b_start();
    wr_byte(8'h72, a); chk(a, "R2", "write address ack", a, 1);
    wr_byte(8'hA5, a); chk(a, "R5", "data ack 1", a, 1);
    wr_byte(8'h3C, a); chk(a, "R5", "data ack 2", a, 1);
    b_stop();
    chk(rxq.size() == 2 && rxq[0] == 8'hA5 && rxq[1] == 8'h3C, "R5", "rx bytes",
        rxq.size() > 1 ? rxq[1] : -1, 8'h3C);
    chk(n_hit == 1 && rd_mode == 0, "R2", "hit count", n_hit, 1);
    chk(n_ackf == 3, "R6", "ack_fall count", n_ackf, 3);
    chk(n_start == 1 && n_stop == 1, "R1", "start/stop count", n_start * 16 + n_stop, 17);

    // mismatch in the lowest address bit, then in the first bit
    clr(); b_start();
    wr_byte(8'h70, a); chk(!a, "R3", "A0 mismatch nack", a, 0);
    wr_byte(8'h55, a); chk(!a, "R3", "deaf data nack", a, 0);
    b_stop();
    b_start();
    wr_byte(8'hF2, a); chk(!a, "R3", "first bit mismatch nack", a, 0);
    wr_byte(8'h72, a); chk(!a, "R3", "address after mismatch ignored", a, 0);
    b_stop();
    chk(rxq.size() == 0 && n_ackf == 0 && n_hit == 0, "R3", "no activity", n_ackf, 0);

    // clocks after a stop with no start
    clr(); m_scl = 0; tick(Q);
    wr_byte(8'h72, a); chk(!a, "R4", "no ack after stop", a, 0);
    wr_byte(8'h12, a); chk(!a, "R4", "no data ack after stop", a, 0);
    b_stop();
    chk(rxq.size() == 0 && n_hit == 0 && n_ackf == 0, "R4", "ignored bytes", n_hit, 0);

    // general call
    clr(); b_start();
    wr_byte(8'h00, a); chk(!a, "R10", "general call nack", a, 0);
    b_stop();
    chk(n_hit == 0, "R10", "general call hit", n_hit, 0);

    // read transfer
    clr(); tx_byte = 8'h5A; txq.push_back(8'h81); txq.push_back(8'hEE);
    b_start();
    wr_byte(8'h73, a); chk(a, "R2", "read address ack", a, 1);
    chk(rd_mode == 1, "R2", "rd_mode", rd_mode, 1);
    rd_byte(1'b1, v); chk(v == 8'h5A, "R7", "read byte 1", v, 8'h5A);
    rd_byte(1'b0, v); chk(v == 8'h81, "R7", "read byte 2", v, 8'h81);
    rd_byte(1'b1, v); chk(v == 8'hFF, "R8", "line released after nack", v, 8'hFF);
    b_stop();
    chk(n_ackf == 3, "R6", "read ack_fall count", n_ackf, 3);

    // repeated start: write then read
    clr(); txq.delete(); tx_byte = 8'hC3;
    b_start();
    wr_byte(8'h72, a); chk(a, "R11", "first address ack", a, 1);
    wr_byte(8'h11, a);
    b_rstart();
    wr_byte(8'h73, a); chk(a, "R11", "address ack after repeated start", a, 1);
    rd_byte(1'b0, v); chk(v == 8'hC3, "R11", "read after repeated start", v, 8'hC3);
    b_stop();
    chk(n_start == 2 && rxq.size() == 1 && rxq[0] == 8'h11, "R11", "two starts",
        n_start, 2);

    // stop in the same high pulse as the start
    clr();
    m_sda = 0; tick(Q); m_sda = 1; tick(Q); m_scl = 0; tick(Q);
    chk(n_stop == 0, "R9", "illegal stop ignored", n_stop, 0);
    wr_byte(8'h72, a); chk(a, "R9", "address after illegal stop", a, 1);
    wr_byte(8'h66, a);
    b_stop();
    chk(n_stop == 1 && rxq.size() == 1 && rxq[0] == 8'h66, "R9", "stop count",
        n_stop, 1);

    // strap low selects 0x38
    clr(); addr_sel = 0; tick(2);
    b_start();
    wr_byte(8'h70, a); chk(a, "R2", "strap low address ack", a, 1);
    b_stop();
    b_start();
    wr_byte(8'h72, a); chk(!a, "R3", "old address rejected", a, 0);
    b_stop();

    tick(10);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule